// File: doc/BRIEF.md
# Interlock-Selected Parameter Address Sequencer

The sequencer walks through a list of parameter addresses, one per clock of its own sequencer clock, so that the logic downstream can fetch and compare each parameter in turn. Which parameters are in the list depends on four interlock inputs. At the start of every pass these four bits are captured as a 4-bit load state. The pass then visits, in ascending slot order, every parameter that the load state enables.

When the last enabled address has been driven, the block spends one cycle with the valid strobe low and the counter-clear pulse high. The next pass then starts on the following clock, using a freshly captured load state. Changes on the interlock inputs during a pass do not disturb that pass.

Top module: `param_addr_seq`

## Requirements
- R1: While `rst_n` is low, `par_vld`, `cnt_clr` and `par_addr` are all 0. The first address of a pass appears after the first rising clock edge on which `rst_n` is high.
- R2: Each parameter has a fixed 4-bit slot:
  - linear power = 0, linear power rate = 1
  - channels 1..8 = 2..9
  - log power = 10, period = 11
  - log-N2 level = 12, log-N2 rate = 13
  - RPSB parameter = 14
  - slot 15 is never emitted.
- R3: The load state is {`ilk_log_n2`, `ilk_log_pwr`, `ilk_lin_pwr`, `ilk_rpsb`}, bit 3 down to bit 0. Which slots belong to a pass depends on it as follows:
  - Slots 2..9 are always included.
  - Slots 0 and 1 are included when bit 1 is 0.
  - Slots 10 and 11 are included when bit 3 is 0.
  - Slots 12 and 13 are included when bit 3 is 1.
  - Slot 14 is included when bit 0 is 1.
  - No other slot is emitted.
- R4: Within a pass, the included slots are driven on `par_addr` one per clock, in strictly ascending order, with `par_vld` high. For load state 0100 the sequence is exactly 0,1,2,...,11.
- R5: On the clock after the last included address, `cnt_clr` is high and `par_vld` is low, for exactly one cycle.
- R6: On the clock after the `cnt_clr` cycle, the first address of the next pass is driven with `par_vld` high.
- R7: The load state is sampled only on the clock that starts a pass. A change during a pass takes effect in the pass that follows the next `cnt_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilk_log_n2 | input | 1 | Log-N2 interlock, load state bit 3 |
| ilk_log_pwr | input | 1 | Log-power interlock, load state bit 2 |
| ilk_lin_pwr | input | 1 | Linear-power interlock, load state bit 1 |
| ilk_rpsb | input | 1 | RPSB interlock, load state bit 0 |
| par_addr | output | 4 | Current parameter slot |
| par_vld | output | 1 | High while `par_addr` holds a listed slot |
| cnt_clr | output | 1 | One-cycle pulse after the last slot of a pass |

## Verification
A wrong captured load state or a corrupted address register shows up on the very next clock. It appears as a slot outside the enabled set, a step that is not ascending, or a pass that ends early or late. An early or late end moves the `cnt_clr` pulse away from the cycle the enabled set predicts. A load state that leaks through during a pass changes the remaining addresses of that same pass. The bench therefore compares every cycle of whole passes, and it changes the interlocks in the middle of one pass.

// File: rtl/param_addr_seq.sv
module param_addr_seq #(
  parameter int NSLOT = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ilk_log_n2,
  input  logic                     ilk_log_pwr,
  input  logic                     ilk_lin_pwr,
  input  logic                     ilk_rpsb,
  output logic [$clog2(NSLOT)-1:0] par_addr,
  output logic                     par_vld,
  output logic                     cnt_clr
);
  localparam int AW = $clog2(NSLOT);

  function automatic logic [NSLOT-1:0] sel_mask(input logic [3:0] ls);
    logic [NSLOT-1:0] m;
    m = '0;
    m[9:2] = '1;
    m[1:0] = ls[1] ? 2'b00 : 2'b11;
    m[11:10] = ls[3] ? 2'b00 : 2'b11;
    m[13:12] = ls[3] ? 2'b11 : 2'b00;
    m[14] = ls[0];
    return m;
  endfunction

  function automatic logic [AW:0] find_from(input logic [NSLOT-1:0] m, input logic [AW:0] from);
    logic [AW:0] r;
    r = (AW+1)'(NSLOT);
    for (int i = NSLOT-1; i >= 0; i--)
      if (m[i] && ((AW+1)'(i) >= from)) r = (AW+1)'(i);
    return r;
  endfunction

  logic [3:0]    ls_q;
  logic [AW-1:0] addr_q;
  logic          vld_q, clr_q;

  wire [3:0]       ls_in    = {ilk_log_n2, ilk_log_pwr, ilk_lin_pwr, ilk_rpsb};
  wire [NSLOT-1:0] cur_mask = sel_mask(ls_q);
  wire [NSLOT-1:0] srch_m   = vld_q ? cur_mask : sel_mask(ls_in);
  wire [AW:0]      srch_f   = vld_q ? ({1'b0, addr_q} + 1'b1) : '0;
  wire [AW:0]      hit      = find_from(srch_m, srch_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q   <= '0;
      addr_q <= '0;
      vld_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else if (!vld_q) begin
      ls_q   <= ls_in;
      addr_q <= hit[AW-1:0];
      vld_q  <= 1'b1;
      clr_q  <= 1'b0;
    end else if (hit[AW]) begin
      vld_q  <= 1'b0;
      clr_q  <= 1'b1;
    end else begin
      addr_q <= hit[AW-1:0];
    end
  end

  assign par_addr = addr_q;
  assign par_vld  = vld_q;
  assign cnt_clr  = clr_q;

  AST_CLR_NOT_VLD: assert property (@(posedge clk) disable iff (!rst_n) cnt_clr |-> !par_vld); // R5
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cnt_clr |=> !cnt_clr); // R5
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n) cnt_clr |=> par_vld); // R6
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n) (par_vld && $past(par_vld)) |-> par_addr > $past(par_addr)); // R4
  AST_IN_SET: assert property (@(posedge clk) disable iff (!rst_n) par_vld |-> cur_mask[par_addr]); // R3
  AST_LS_HELD: assert property (@(posedge clk) disable iff (!rst_n) (par_vld && $past(par_vld)) |-> $stable(ls_q)); // R7
  AST_END_CLR: assert property (@(posedge clk) disable iff (!rst_n) (par_vld && ((cur_mask >> ({1'b0, par_addr} + 1'b1)) == '0)) |=> cnt_clr); // R5
  AST_NO_SLOT15: assert property (@(posedge clk) disable iff (!rst_n) par_vld |-> par_addr != 4'd15); // R2
endmodule

// File: tb/param_addr_seq_tb.sv
module param_addr_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ilk_log_n2 = 1'b0, ilk_log_pwr = 1'b0, ilk_lin_pwr = 1'b0, ilk_rpsb = 1'b0;
  logic [3:0] par_addr;
  logic par_vld, cnt_clr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  param_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .ilk_log_n2(ilk_log_n2), .ilk_log_pwr(ilk_log_pwr),
    .ilk_lin_pwr(ilk_lin_pwr), .ilk_rpsb(ilk_rpsb),
    .par_addr(par_addr), .par_vld(par_vld), .cnt_clr(cnt_clr)
  );

  localparam logic [19:0] VEC [6] = '{
    {4'b0100, 16'h0FFF}, {4'b0000, 16'h0FFF}, {4'b1111, 16'h73FC},
    {4'b0011, 16'h4FFC}, {4'b1000, 16'h33FF}, {4'b0101, 16'h4FFF}
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_ls(input logic [3:0] ls);
    {ilk_log_n2, ilk_log_pwr, ilk_lin_pwr, ilk_rpsb} = ls;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic walk(input logic [15:0] mask, input string req);
    for (int s = 0; s < 16; s++)
      if (mask[s]) begin
        step();
        chk(req, "addr", 16'(par_addr), 16'(s));
        chk(req, "vld", 16'(par_vld), 16'd1);
        chk(req, "clr", 16'(cnt_clr), 16'd0);
      end
    step();
    chk("R5", "clr at end", 16'(cnt_clr), 16'd1);
    chk("R5", "vld at end", 16'(par_vld), 16'd0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_ls(4'b0100);
    step(); step();
    chk("R1", "vld in reset", 16'(par_vld), 16'd0);
    chk("R1", "clr in reset", 16'(cnt_clr), 16'd0);
    chk("R1", "addr in reset", 16'(par_addr), 16'd0);
    rst_n = 1'b1;
    // R4: exact order for load state 0100
    for (int k = 0; k < 12; k++) begin
      step();
      chk("R4", "0100 order", 16'(par_addr), 16'(k));
      chk("R4", "0100 vld", 16'(par_vld), 16'd1);
    end
    step();
    chk("R5", "clr pulse", 16'(cnt_clr), 16'd1);
    chk("R5", "vld low", 16'(par_vld), 16'd0);
    // R3 R6: table of load states, passes back to back
    foreach (VEC[v]) begin
      set_ls(VEC[v][19:16]);
      walk(VEC[v][15:0], "R3");
    end
    // R7: interlock change mid-pass
    set_ls(4'b0100);
    for (int k = 0; k < 3; k++) step();
    set_ls(4'b1111);
    for (int k = 3; k < 12; k++) begin
      step();
      chk("R7", "pass kept", 16'(par_addr), 16'(k));
    end
    step();
    chk("R7", "clr after held pass", 16'(cnt_clr), 16'd1);
    step();
    chk("R6", "restart vld", 16'(par_vld), 16'd1);
    chk("R7", "new ls first", 16'(par_addr), 16'd2);
    chk("R6", "clr dropped", 16'(cnt_clr), 16'd0);
    // R1: reset mid-pass
    step(); step();
    rst_n = 1'b0;
    #1;
    chk("R1", "async vld", 16'(par_vld), 16'd0);
    chk("R1", "async addr", 16'(par_addr), 16'd0);
    chk("R1", "async clr", 16'(cnt_clr), 16'd0);
    @(negedge clk);
    set_ls(4'b0011);
    rst_n = 1'b1;
    walk(16'h4FFC, "R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule